// File: doc/BRIEF.md
# RTC interrupt flag controller

This block holds the interrupt enables and the latched event flags of a real-time clock and turns them into a single interrupt request. Three event sources feed it. The first is a periodic event, taken from the rising edge of one bit of a free-running divider count that a 4-bit rate field selects. The second is an alarm match pulse. The third is an update-complete pulse. Each event sets its own sticky flag. A flag only raises the request when its enable is also set.

The host writes the three enables through a byte-wide enable port and reads them back from the same byte layout. It reads the status byte while pulsing a read strobe. The value presented in that cycle is the pre-clear value, and at the closing clock edge all three flags clear. A small two-state machine drives the request line. In `IRQ_IDLE` the line is low. The transition IDLE→RAISED happens when any enabled flag will be set after the coming edge. The transition RAISED→IDLE happens when none will be. The line is therefore a registered level, and the top bit of the status byte mirrors it.

Three clearing conditions apply, each to its own group. A hardware reset clears everything. A software reset, or the clock being disabled, clears the periodic and update enables and flags. A low valid-time indication holds the alarm enable and flag at zero.

Top module: `rtc_irq_flags`

## Requirements
- R1: The status byte `stat_rdata` carries the request level in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3 to 0 are always 0.
- R2: `irq` is a registered active-high level equal to (update enable and update flag) or (alarm enable and alarm flag) or (periodic enable and periodic flag). It changes at the clock edge where the flags or enables change, and status bit 7 shows the same value.
- R3: During a cycle with `stat_rd` high, `stat_rdata` shows the flags as they were before the read. At the end of that cycle all three flags clear, so `irq` falls unless a new event arrives.
- R4: An event arriving in the same cycle as a status read sets its flag after the clear, so the event is not lost.
- R5: With `rate_sel` = 0 no periodic event occurs. With `rate_sel` = n (1 to 15), a periodic event occurs in a cycle where `div_count[n-1]` is 1 and was 0 in the previous cycle, or 0 since reset. The periodic flag sets at that cycle's edge.
- R6: While `sw_rst` is high or `rtc_en` is low, the periodic and update enables and flags are cleared and stay cleared, ignoring writes and events.
- R7: While `time_valid` is low, the alarm enable and the alarm flag are held at 0, ignoring writes and alarm pulses.
- R8: An enable write (`en_wr` high) loads the periodic enable from bit 6, the alarm enable from bit 5 and the update enable from bit 4. `en_rdata` returns them in those bit positions, and bit 3 and all other bits read 0 whatever was written.
- R9: Asserting `rst_n` low clears all enables, flags and `irq`.
- R10: Flags latch their events whatever the enable settings are. A disabled flag shows in the status byte but does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Software reset of the clock, active high |
| rtc_en | input | 1 | Clock enabled; low clears the periodic and update state |
| time_valid | input | 1 | Valid-time indication; low holds the alarm state at 0 |
| div_count | input | DIV_W (15) | Free-running divider count |
| rate_sel | input | 4 | Periodic tap select, 0 disables |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-complete pulse |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read value |
| stat_rd | input | 1 | Status read strobe; clears flags at cycle end |
| stat_rdata | output | 8 | Status byte |
| irq | output | 1 | Interrupt request level |

## Verification
Directed cases come first. They isolate a lone update event with all enables set, a read colliding with an alarm pulse, events with their enables off, writes made while each clearing condition is active, and the periodic tap with rate 0 against rate 1. These separate a missing mask from a missing latch, and a lost event from a late clear. A random phase then mixes all inputs, including rare disables, software resets, valid-time drops and rate changes, against a cycle model. This phase exposes wrong precedence between clears, writes and events, and a periodic edge detector that counts levels or falling edges.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    // enable byte positions, decoded by the host
    localparam int PIE_BIT = 6;
    localparam int AIE_BIT = 5;
    localparam int UIE_BIT = 4;
    // status byte positions, decoded by the host
    localparam int IRQ_BIT = 7;
    localparam int PF_BIT  = 6;
    localparam int AF_BIT  = 5;
    localparam int UF_BIT  = 4;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/rtc_tap_edge.sv
module rtc_tap_edge #(
    parameter int DIV_W = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_count,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             per_evt
);
    localparam int NTAP = (DIV_W < (1 << SEL_W) - 1) ? DIV_W : (1 << SEL_W) - 1;

    logic tap_now;
    logic tap_q;

    always_comb begin
        tap_now = 1'b0;
        for (int i = 0; i < NTAP; i++) begin
            if (rate_sel == SEL_W'(i + 1)) tap_now = div_count[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= 1'b0;
        else        tap_q <= tap_now;
    end

    assign per_evt = tap_now & ~tap_q;

    // R5
    no_double_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_evt ##1 $stable(rate_sel)) |-> !per_evt);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rst,
    input  logic       rtc_en,
    input  logic       time_valid,
    input  logic       en_wr,
    input  logic [7:0] en_wdata,
    input  logic       per_evt,
    input  logic       alm_evt,
    input  logic       upd_evt,
    input  logic       stat_rd,
    output logic       pie_q,
    output logic       aie_q,
    output logic       uie_q,
    output logic       pf_q,
    output logic       af_q,
    output logic       uf_q,
    output logic       req_nxt
);
    logic soft_clr;
    logic pie_d, aie_d, uie_d, pf_d, af_d, uf_d;

    assign soft_clr = sw_rst | ~rtc_en;

    always_comb begin
        // enables: clears beat writes
        pie_d = soft_clr    ? 1'b0 : (en_wr ? en_wdata[PIE_BIT] : pie_q);
        uie_d = soft_clr    ? 1'b0 : (en_wr ? en_wdata[UIE_BIT] : uie_q);
        aie_d = !time_valid ? 1'b0 : (en_wr ? en_wdata[AIE_BIT] : aie_q);
        // flags: read clears, a same-cycle event sets afterwards
        pf_d  = soft_clr    ? 1'b0 : (per_evt | (pf_q & ~stat_rd));
        uf_d  = soft_clr    ? 1'b0 : (upd_evt | (uf_q & ~stat_rd));
        af_d  = !time_valid ? 1'b0 : (alm_evt | (af_q & ~stat_rd));
        req_nxt = (pie_d & pf_d) | (aie_d & af_d) | (uie_d & uf_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pie_q <= 1'b0;
            aie_q <= 1'b0;
            uie_q <= 1'b0;
            pf_q  <= 1'b0;
            af_q  <= 1'b0;
            uf_q  <= 1'b0;
        end else begin
            pie_q <= pie_d;
            aie_q <= aie_d;
            uie_q <= uie_d;
            pf_q  <= pf_d;
            af_q  <= af_d;
            uf_q  <= uf_d;
        end
    end

    // R6
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst || !rtc_en) |=> (!pf_q && !uf_q && !pie_q && !uie_q));
    // R7
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !time_valid |=> (!af_q && !aie_q));
    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !upd_evt) |=> !uf_q);
    // R4
    event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && rtc_en && !sw_rst) |=> uf_q);
endmodule

// File: rtl/rtc_irq_fsm.sv
module rtc_irq_fsm
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_nxt,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (req_nxt)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!req_nxt) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int DIV_W = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             rtc_en,
    input  logic             time_valid,
    input  logic [DIV_W-1:0] div_count,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             alarm_evt,
    input  logic             update_evt,
    input  logic             en_wr,
    input  logic [7:0]       en_wdata,
    output logic [7:0]       en_rdata,
    input  logic             stat_rd,
    output logic [7:0]       stat_rdata,
    output logic             irq
);
    logic per_evt;
    logic pie_q, aie_q, uie_q, pf_q, af_q, uf_q;
    logic req_nxt;

    rtc_tap_edge #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_tap (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_count (div_count),
        .rate_sel  (rate_sel),
        .per_evt   (per_evt)
    );

    rtc_flag_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .rtc_en     (rtc_en),
        .time_valid (time_valid),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .per_evt    (per_evt),
        .alm_evt    (alarm_evt),
        .upd_evt    (update_evt),
        .stat_rd    (stat_rd),
        .pie_q      (pie_q),
        .aie_q      (aie_q),
        .uie_q      (uie_q),
        .pf_q       (pf_q),
        .af_q       (af_q),
        .uf_q       (uf_q),
        .req_nxt    (req_nxt)
    );

    rtc_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_nxt (req_nxt),
        .irq     (irq)
    );

    always_comb begin
        en_rdata          = 8'h00;
        en_rdata[PIE_BIT] = pie_q;
        en_rdata[AIE_BIT] = aie_q;
        en_rdata[UIE_BIT] = uie_q;
        stat_rdata          = 8'h00;
        stat_rdata[IRQ_BIT] = irq;
        stat_rdata[PF_BIT]  = pf_q;
        stat_rdata[AF_BIT]  = af_q;
        stat_rdata[UF_BIT]  = uf_q;
    end

    // R2
    irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((pie_q && pf_q) || (aie_q && af_q) || (uie_q && uf_q)));
endmodule

// File: tb/sim_rtc_irq_flags.sv
module sim_rtc_irq_flags;
    localparam int DIV_W = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sw_rst = 1'b0;
    logic             rtc_en = 1'b1;
    logic             time_valid = 1'b1;
    logic [DIV_W-1:0] div_count = '0;
    logic [3:0]       rate_sel = 4'd0;
    logic             alarm_evt = 1'b0;
    logic             update_evt = 1'b0;
    logic             en_wr = 1'b0;
    logic [7:0]       en_wdata = 8'h00;
    logic [7:0]       en_rdata;
    logic             stat_rd = 1'b0;
    logic [7:0]       stat_rdata;
    logic             irq;

    int  checks = 0;
    int  errors = 0;
    bit  chk_on = 1'b0;
    bit  done = 1'b0;

    // reference model state
    logic m_pie, m_aie, m_uie, m_pf, m_af, m_uf, m_tapq, m_irq;
    logic t_tap, t_pev, t_soft;

    always #10 clk = ~clk;

    rtc_irq_flags #(.DIV_W(DIV_W), .SEL_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rtc_en(rtc_en),
        .time_valid(time_valid), .div_count(div_count), .rate_sel(rate_sel),
        .alarm_evt(alarm_evt), .update_evt(update_evt), .en_wr(en_wr),
        .en_wdata(en_wdata), .en_rdata(en_rdata), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .irq(irq)
    );

    function automatic logic [7:0] exp_stat();
        return {m_irq, m_pf, m_af, m_uf, 4'b0000};
    endfunction

    function automatic logic [7:0] exp_en();
        return {1'b0, m_pie, m_aie, m_uie, 4'b0000};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_pie, m_aie, m_uie, m_pf, m_af, m_uf, m_tapq, m_irq} = '0;
        end else begin
            t_tap  = (rate_sel != 0) ? div_count[rate_sel - 4'd1] : 1'b0;
            t_pev  = t_tap & ~m_tapq;
            m_tapq = t_tap;
            t_soft = sw_rst | ~rtc_en;
            m_pie = t_soft ? 1'b0 : (en_wr ? en_wdata[6] : m_pie);
            m_uie = t_soft ? 1'b0 : (en_wr ? en_wdata[4] : m_uie);
            m_aie = !time_valid ? 1'b0 : (en_wr ? en_wdata[5] : m_aie);
            m_pf  = t_soft ? 1'b0 : (t_pev | (m_pf & ~stat_rd));
            m_uf  = t_soft ? 1'b0 : (update_evt | (m_uf & ~stat_rd));
            m_af  = !time_valid ? 1'b0 : (alarm_evt | (m_af & ~stat_rd));
            m_irq = (m_pie & m_pf) | (m_aie & m_af) | (m_uie & m_uf);
        end
    end

    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            chk("R1 status byte", stat_rdata, exp_stat());
            chk("R2 irq level", {7'b0, irq}, {7'b0, m_irq});
            chk("R8 enable byte", en_rdata, exp_en());
        end
    end

    task automatic tick();
        @(negedge clk);
        div_count = div_count + 1'b1;
    endtask

    task automatic idle_inputs();
        en_wr = 1'b0; stat_rd = 1'b0; alarm_evt = 1'b0; update_evt = 1'b0; sw_rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk_on = 1'b1;
        // R9 reset state
        chk("R9 status after reset", stat_rdata, 8'h00);
        chk("R9 enables after reset", en_rdata, 8'h00);
        chk("R9 irq after reset", {7'b0, irq}, 8'h00);

        // R8 all enables, reserved bits dropped
        en_wr = 1'b1; en_wdata = 8'hFF; tick(); idle_inputs();
        chk("R8 write all ones", en_rdata, 8'h70);

        // R2 update event raises irq
        update_evt = 1'b1; tick(); idle_inputs();
        chk("R2 update sets flag and irq", stat_rdata, 8'h90);

        // R3 read returns pre-clear value then clears
        stat_rd = 1'b1;
        chk("R3 read value before clear", stat_rdata, 8'h90);
        tick(); idle_inputs();
        chk("R3 flags cleared by read", stat_rdata, 8'h00);
        chk("R3 irq dropped by read", {7'b0, irq}, 8'h00);

        // R4 event coinciding with read
        stat_rd = 1'b1; alarm_evt = 1'b1; tick(); idle_inputs();
        chk("R4 alarm kept across read", stat_rdata, 8'hA0);
        stat_rd = 1'b1; tick(); idle_inputs();

        // R10 flag latches with enable off
        en_wr = 1'b1; en_wdata = 8'h00; tick(); idle_inputs();
        update_evt = 1'b1; tick(); idle_inputs();
        chk("R10 masked flag visible", stat_rdata, 8'h10);
        en_wr = 1'b1; en_wdata = 8'h10; tick(); idle_inputs();
        chk("R2 late enable raises irq", stat_rdata, 8'h90);
        stat_rd = 1'b1; tick(); idle_inputs();

        // R7 valid-time low holds alarm state
        time_valid = 1'b0; alarm_evt = 1'b1; en_wr = 1'b1; en_wdata = 8'hFF;
        tick(); idle_inputs();
        chk("R7 alarm enable held", en_rdata, 8'h50);
        chk("R7 alarm flag held", stat_rdata, 8'h00);
        time_valid = 1'b1;
        en_wr = 1'b1; en_wdata = 8'hFF; tick(); idle_inputs();

        // R6 software reset clears periodic and update state
        sw_rst = 1'b1; update_evt = 1'b1; tick(); idle_inputs();
        chk("R6 soft reset enables", en_rdata, 8'h20);
        chk("R6 soft reset flags", stat_rdata, 8'h00);
        rtc_en = 1'b0; en_wr = 1'b1; en_wdata = 8'hFF; update_evt = 1'b1;
        tick(); idle_inputs();
        chk("R6 disabled ignores write", en_rdata, 8'h20);
        rtc_en = 1'b1;

        // R5 periodic tap
        en_wr = 1'b1; en_wdata = 8'hFF; rate_sel = 4'd0; tick(); idle_inputs();
        for (int i = 0; i < 40; i++) tick();
        chk("R5 rate zero no periodic", stat_rdata & 8'h40, 8'h00);
        rate_sel = 4'd1;
        repeat (3) tick();
        chk("R5 rate one sets periodic", stat_rdata & 8'h40, 8'h40);
        stat_rd = 1'b1; rate_sel = 4'd0; tick(); idle_inputs();

        // random phase
        for (int n = 0; n < 3000; n++) begin
            tick();
            idle_inputs();
            rtc_en     = ($urandom % 24) != 0;
            time_valid = ($urandom % 24) != 0;
            sw_rst     = ($urandom % 40) == 0;
            en_wr      = ($urandom % 8) == 0;
            en_wdata   = 8'($urandom);
            stat_rd    = ($urandom % 6) == 0;
            alarm_evt  = ($urandom % 8) == 0;
            update_evt = ($urandom % 8) == 0;
            if (($urandom % 64) == 0) rate_sel = 4'($urandom);
        end
        tick(); idle_inputs();
        tick();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule